// File: doc/BRIEF.md
# Two-Group Interrupt Priority Arbiter

This block sits between the interrupt sources of a generic interrupt controller and one CPU. Each source has an enable bit, a pending bit, a group bit and an 8-bit priority. A smaller priority number means a more urgent interrupt. Every cycle the block finds the most urgent source that is both enabled and pending. It compares that source with the CPU's priority mask and with the priority the CPU is running at. It then chooses whether to raise the fast interrupt line (FIQ), the normal interrupt line (IRQ), or neither. It also reports the identifier of the interrupt the CPU would take next.

Interrupts are split into two groups. Group 0 can be routed to FIQ. Group 1 always uses IRQ. Each group has its own enable at the distributor and another at the CPU interface. The two-group scheme is used when the controller revision input is 2 or more, or when security extensions are present. Otherwise the block uses a single-group scheme that raises IRQ only. The source search is a combinational comparison tree. The line and identifier decisions are registered on the clock edge.

Top module: `grp_irq_arbiter`

## Requirements
- R1: Among qualifying sources the one with the smallest priority value wins. On equal priorities the source with the lowest index wins.
- R2: A source takes part only when its enable bit and its pending bit are both 1. A disabled or non-pending source has no effect on the outputs, whatever its priority.
- R3: `pend_id_o` shows the winner's index only when the winner's priority is strictly below `prio_mask`. Otherwise it shows 1023. IRQ or FIQ is never raised while `pend_id_o` is 1023.
- R4: In two-group mode, if both distributor group enables are 0, or both CPU-interface group enables are 0, then IRQ and FIQ are 0 and `pend_id_o` is 1023.
- R5: An interrupt is signalled only when its priority is strictly below `run_prio`. In two-group mode its group must also be enabled at the distributor (`dist_grp0_en` for group bit 0, `dist_grp1_en` for group bit 1).
- R6: A signalled group 0 winner (group bit 0) raises FIQ when `cpuif_fiq_en` and `cpuif_grp0_en` are both 1. It raises nothing when `cpuif_fiq_en` is 1 and `cpuif_grp0_en` is 0. When `cpuif_fiq_en` is 0 it raises IRQ if `cpuif_grp0_en` is 1.
- R7: A signalled group 1 winner (group bit 1) raises IRQ only, and only when `cpuif_grp1_en` is 1.
- R8: `irq_o` and `fiq_o` are never 1 in the same cycle.
- R9: Two-group mode is active when `ctrl_rev` is 2 or more, or when `sec_ext` is 1. Otherwise the single-group mode applies. In that mode the group bits are ignored and the block is enabled only by `dist_grp0_en` together with `cpuif_grp0_en`; if either is 0, the lines are 0 and `pend_id_o` is 1023. In single-group mode FIQ is never raised, and IRQ follows the R5 running-priority test.
- R10: The outputs show the inputs sampled at the previous rising clock edge. While `rst_n` is low the outputs are `irq_o`=0, `fiq_o`=0 and `pend_id_o`=1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NUM_SRC | Per-source enable |
| src_pend | input | NUM_SRC | Per-source pending |
| src_grp1 | input | NUM_SRC | Per-source group bit: 0 means group 0, 1 means group 1 |
| src_prio | input | NUM_SRC*8 | Source i priority in bits [8i+7:8i] |
| dist_grp0_en | input | 1 | Distributor enable for group 0 |
| dist_grp1_en | input | 1 | Distributor enable for group 1 |
| cpuif_grp0_en | input | 1 | CPU-interface enable for group 0 |
| cpuif_grp1_en | input | 1 | CPU-interface enable for group 1 |
| cpuif_fiq_en | input | 1 | Route group 0 to FIQ |
| prio_mask | input | 8 | CPU priority mask |
| run_prio | input | 8 | CPU running priority (0xFF when idle) |
| ctrl_rev | input | 4 | Controller revision |
| sec_ext | input | 1 | Security extensions present |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| pend_id_o | output | 10 | Highest pending identifier, 1023 if none |

## Verification
The bench uses eight sources. It sweeps every combination of the five enable bits in three mode settings: revision 1, revision 2, and revision 1 with security extensions. Each combination is tried against source patterns whose priorities are packed into a narrow range, so ties are common and the mask and running-priority limits are crossed often. These runs separate mistakes in tie order and in the strict comparisons, and they show which enable or group bit is wrong. Directed cases then place a priority exactly on the mask and exactly on the running priority. They also hide an urgent source behind a cleared enable or pending bit, show the FIQ-to-IRQ fallback, and check the one-cycle output latency.

// File: rtl/grp_arb_pkg.sv
package grp_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    LINE_NONE = 2'd0,
    LINE_IRQ  = 2'd1,
    LINE_FIQ  = 2'd2
  } line_e;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
    logic              grp1;
  } cand_t;
endpackage

// File: rtl/grp_arb_search.sv
module grp_arb_search
  import grp_arb_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_pend,
  input  logic [NUM_SRC-1:0]        src_grp1,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  output cand_t                     best
);
  localparam int LVLS   = $clog2(NUM_SRC);
  localparam int LEAVES = 1 << LVLS;

  // Heap layout: node k merges 2k and 2k+1, leaves sit at LEAVES+i.
  cand_t nodes [1:2*LEAVES-1];

  // The left child holds lower indices, so it keeps ties.
  function automatic cand_t pick(cand_t lo, cand_t hi);
    if (lo.valid && (!hi.valid || lo.prio <= hi.prio)) return lo;
    return hi;
  endfunction

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign nodes[LEAVES+i] = '{valid: src_en[i] & src_pend[i],
                                 prio:  src_prio[i*PRIO_W +: PRIO_W],
                                 id:    ID_W'(i),
                                 grp1:  src_grp1[i]};
    end else begin : g_pad
      assign nodes[LEAVES+i] = '0;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign nodes[k] = pick(nodes[2*k], nodes[2*k+1]);
  end

  assign best = nodes[1];
endmodule

// File: rtl/grp_arb_route.sv
module grp_arb_route
  import grp_arb_pkg::*;
(
  input  cand_t              best,
  input  logic               dist_grp0_en,
  input  logic               dist_grp1_en,
  input  logic               cpuif_grp0_en,
  input  logic               cpuif_grp1_en,
  input  logic               cpuif_fiq_en,
  input  logic [PRIO_W-1:0]  prio_mask,
  input  logic [PRIO_W-1:0]  run_prio,
  input  logic [3:0]         ctrl_rev,
  input  logic               sec_ext,
  output line_e              nxt_line,
  output logic [ID_W-1:0]    nxt_id
);
  logic grouped;
  logic blocked;
  logic beats_mask;
  logic beats_run;
  logic sig_g0;
  logic sig_g1;

  always_comb begin
    grouped    = (ctrl_rev >= 4'd2) || sec_ext;
    blocked    = grouped ? ((!dist_grp0_en && !dist_grp1_en) ||
                            (!cpuif_grp0_en && !cpuif_grp1_en))
                         : (!dist_grp0_en || !cpuif_grp0_en);
    beats_mask = best.valid && (best.prio < prio_mask) && !blocked;
    beats_run  = best.prio < run_prio;
    sig_g0     = beats_mask && beats_run && !best.grp1 && dist_grp0_en;
    sig_g1     = beats_mask && beats_run &&  best.grp1 && dist_grp1_en;

    nxt_id   = beats_mask ? best.id : SPURIOUS_ID;
    nxt_line = LINE_NONE;
    if (!grouped) begin
      if (beats_mask && beats_run) nxt_line = LINE_IRQ;
    end else if (sig_g0) begin
      if (cpuif_fiq_en) begin
        if (cpuif_grp0_en) nxt_line = LINE_FIQ;
      end else if (cpuif_grp0_en) begin
        nxt_line = LINE_IRQ;
      end
    end else if (sig_g1) begin
      if (cpuif_grp1_en) nxt_line = LINE_IRQ;
    end
  end
endmodule

// File: rtl/grp_arb_outreg.sv
module grp_arb_outreg
  import grp_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  line_e           nxt_line,
  input  logic [ID_W-1:0] nxt_id,
  output logic            irq_q,
  output logic            fiq_q,
  output logic [ID_W-1:0] id_q
);
  logic            irq_d;
  logic            fiq_d;
  logic            upd_en;

  always_comb begin
    irq_d  = (nxt_line == LINE_IRQ);
    fiq_d  = (nxt_line == LINE_FIQ);
    upd_en = (irq_d != irq_q) || (fiq_d != fiq_q) || (nxt_id != id_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      id_q  <= SPURIOUS_ID;
    end else if (upd_en) begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
      id_q  <= nxt_id;
    end
  end
endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
  import grp_arb_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_pend,
  input  logic [NUM_SRC-1:0]        src_grp1,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic                      dist_grp0_en,
  input  logic                      dist_grp1_en,
  input  logic                      cpuif_grp0_en,
  input  logic                      cpuif_grp1_en,
  input  logic                      cpuif_fiq_en,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic [PRIO_W-1:0]         run_prio,
  input  logic [3:0]                ctrl_rev,
  input  logic                      sec_ext,
  output logic                      irq_o,
  output logic                      fiq_o,
  output logic [ID_W-1:0]           pend_id_o
);
  cand_t           best;
  line_e           nxt_line;
  logic [ID_W-1:0] nxt_id;

  grp_arb_search #(.NUM_SRC(NUM_SRC)) u_search (
    .src_en   (src_en),
    .src_pend (src_pend),
    .src_grp1 (src_grp1),
    .src_prio (src_prio),
    .best     (best)
  );

  grp_arb_route u_route (
    .best          (best),
    .dist_grp0_en  (dist_grp0_en),
    .dist_grp1_en  (dist_grp1_en),
    .cpuif_grp0_en (cpuif_grp0_en),
    .cpuif_grp1_en (cpuif_grp1_en),
    .cpuif_fiq_en  (cpuif_fiq_en),
    .prio_mask     (prio_mask),
    .run_prio      (run_prio),
    .ctrl_rev      (ctrl_rev),
    .sec_ext       (sec_ext),
    .nxt_line      (nxt_line),
    .nxt_id        (nxt_id)
  );

  grp_arb_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt_line (nxt_line),
    .nxt_id   (nxt_id),
    .irq_q    (irq_o),
    .fiq_q    (fiq_o),
    .id_q     (pend_id_o)
  );
endmodule

// File: rtl/grp_irq_arbiter_chk.sv
module grp_irq_arbiter_chk
  import grp_arb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            dist_grp0_en,
  input logic            dist_grp1_en,
  input logic            cpuif_grp0_en,
  input logic            cpuif_grp1_en,
  input logic            cpuif_fiq_en,
  input logic [7:0]      run_prio,
  input logic [3:0]      ctrl_rev,
  input logic            sec_ext,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [ID_W-1:0] pend_id_o
);
  logic seen;
  logic two_grp;
  logic all_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assign two_grp = (ctrl_rev >= 4'd2) || sec_ext;
  assign all_off = (!dist_grp0_en && !dist_grp1_en) || (!cpuif_grp0_en && !cpuif_grp1_en);

  AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o)); // R8

  AST_LINE_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> (pend_id_o != SPURIOUS_ID)); // R3

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(two_grp && all_off)) |-> (!irq_o && !fiq_o && pend_id_o == SPURIOUS_ID)); // R4

  AST_FIQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && fiq_o) |-> $past(two_grp && cpuif_fiq_en && cpuif_grp0_en && dist_grp0_en)); // R6

  AST_SINGLE_NO_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!two_grp)) |-> !fiq_o); // R9

  AST_RUN_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(run_prio == 8'd0)) |-> (!irq_o && !fiq_o)); // R5
endmodule

bind grp_irq_arbiter grp_irq_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dist_grp0_en  (dist_grp0_en),
  .dist_grp1_en  (dist_grp1_en),
  .cpuif_grp0_en (cpuif_grp0_en),
  .cpuif_grp1_en (cpuif_grp1_en),
  .cpuif_fiq_en  (cpuif_fiq_en),
  .run_prio      (run_prio),
  .ctrl_rev      (ctrl_rev),
  .sec_ext       (sec_ext),
  .irq_o         (irq_o),
  .fiq_o         (fiq_o),
  .pend_id_o     (pend_id_o)
);

// File: tb/grp_irq_arbiter_tb.sv
module grp_irq_arbiter_tb;
  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   en, pd, gp;
  logic [N*8-1:0] pr;
  logic           dg0, dg1, cg0, cg1, fen, sec;
  logic [7:0]     mask, run;
  logic [3:0]     rev;
  logic           irq, fiq;
  logic [9:0]     id;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] lf = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  grp_irq_arbiter #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_en(en), .src_pend(pd), .src_grp1(gp),
    .src_prio(pr), .dist_grp0_en(dg0), .dist_grp1_en(dg1),
    .cpuif_grp0_en(cg0), .cpuif_grp1_en(cg1), .cpuif_fiq_en(fen),
    .prio_mask(mask), .run_prio(run), .ctrl_rev(rev), .sec_ext(sec),
    .irq_o(irq), .fiq_o(fiq), .pend_id_o(id)
  );

  // Expected {irq, fiq, id} derived from the requirement list.
  function automatic logic [11:0] expect_out();
    int   bi = -1;
    int   bp = 256;
    logic two = (rev >= 4'd2) || sec;
    logic off;
    logic e_irq = 1'b0, e_fiq = 1'b0;
    logic [9:0] e_id = 10'd1023;
    for (int i = 0; i < N; i++)
      if (en[i] && pd[i] && int'(pr[i*8 +: 8]) < bp) begin
        bp = int'(pr[i*8 +: 8]);
        bi = i;
      end
    off = two ? ((!dg0 && !dg1) || (!cg0 && !cg1)) : (!dg0 || !cg0);
    if (!off && bi >= 0 && bp < int'(mask)) begin
      e_id = 10'(bi);
      if (bp < int'(run)) begin
        if (!two) e_irq = 1'b1;
        else if (!gp[bi] && dg0) begin
          if (fen) e_fiq = cg0;
          else     e_irq = cg0;
        end else if (gp[bi] && dg1) e_irq = cg1;
      end
    end
    return {e_irq, e_fiq, e_id};
  endfunction

  task automatic check(input string tag, input logic [11:0] exp);
    n_run++;
    if ({irq, fiq, id} !== exp) begin
      n_fail++;
      $display("FAIL %s: got irq=%0b fiq=%0b id=%0d, expected irq=%0b fiq=%0b id=%0d",
               tag, irq, fiq, id, exp[11], exp[10], exp[9:0]);
    end
  endtask

  // Inputs were set at a falling edge; one rising edge later sample.
  task automatic settle_check(input string tag);
    logic [11:0] e = expect_out();
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic step_lf();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
  endtask

  task automatic set_prio(input int i, input int p);
    pr[i*8 +: 8] = 8'(p);
  endtask

  task automatic clear_all();
    en = '0; pd = '0; gp = '0; pr = '1;
    dg0 = 1; dg1 = 1; cg0 = 1; cg1 = 1; fen = 0;
    mask = 8'hFF; run = 8'hFF; rev = 4'd2; sec = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: R10 run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clear_all();
    en = '1; pd = '1; pr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset state", {1'b0, 1'b0, 10'd1023});
    rst_n = 1'b1;
    @(negedge clk);

    // R1 tie: sources 3 and 5 equal, lowest index wins
    clear_all();
    en = '1; pd = '1;
    set_prio(5, 4); set_prio(3, 4); set_prio(6, 9);
    settle_check("R1 tie lowest index");
    check("R1 tie id", {1'b1, 1'b0, 10'd3});
    // R2 urgent source disabled / not pending
    set_prio(0, 1); en[0] = 0;
    settle_check("R2 disabled ignored");
    en[0] = 1; pd[0] = 0;
    settle_check("R2 not pending ignored");
    // R3 priority equal to mask
    pd[0] = 1; mask = 8'd1;
    settle_check("R3 equal mask spurious");
    check("R3 equal mask value", {1'b0, 1'b0, 10'd1023});
    // R5 priority equal to running
    mask = 8'hFF; run = 8'd1;
    settle_check("R5 equal running no line");
    dg0 = 0;
    run = 8'hFF;
    settle_check("R5 distributor group gate");
    // R6 FIQ routing and fallback
    dg0 = 1; fen = 1;
    settle_check("R6 fiq raised");
    check("R6 fiq value", {1'b0, 1'b1, 10'd0});
    cg0 = 0;
    settle_check("R6 fiq en without grp0 silent");
    // R7 group 1 winner
    cg0 = 1; gp[0] = 1; cg1 = 0;
    settle_check("R7 grp1 blocked at cpu");
    cg1 = 1;
    settle_check("R7 grp1 irq");
    // R4 both cpu enables clear
    cg0 = 0; cg1 = 0;
    settle_check("R4 cpu off");
    // R9 single-group mode ignores group bits, no FIQ
    cg0 = 1; cg1 = 1; rev = 4'd1; sec = 0;
    settle_check("R9 single group irq");
    dg0 = 0;
    settle_check("R9 single group off");
    // R10 latency: output holds until the edge
    clear_all(); en = '1; pd = '1; pr = '0;
    @(negedge clk);
    @(negedge clk);
    en = '0;
    #1 check("R10 held before edge", {1'b1, 1'b0, 10'd0});
    @(negedge clk);
    check("R10 updated after edge", {1'b0, 1'b0, 10'd1023});

    // Sweep: modes x control bits x source patterns
    for (int m = 0; m < 3; m++) begin
      for (int c = 0; c < 32; c++) begin
        for (int p = 0; p < 8; p++) begin
          rev = (m == 1) ? 4'd2 : 4'd1;
          sec = (m == 2);
          {dg0, dg1, cg0, cg1, fen} = 5'(c);
          step_lf();
          en = lf[7:0]; pd = lf[15:8] | lf[23:16]; gp = lf[31:24];
          for (int i = 0; i < N; i++) begin
            step_lf();
            set_prio(i, int'(lf[4:0]));
          end
          mask = (p % 3 == 0) ? 8'h10 : ((p % 3 == 1) ? 8'h20 : 8'hFF);
          run  = (p % 4 == 0) ? 8'h08 : ((p % 4 == 1) ? 8'h18 : 8'hFF);
          settle_check("R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule